// File: doc/BRIEF.md
# Chained Non-Restoring Division Step Unit

This block performs one bit of a non-restoring binary division per step and keeps its working state in three status bits: `q_bit` (the quotient/sign tracking bit), `m_bit` (the divisor sign) and `t_bit` (the freshly produced quotient bit). These bits are visible at the ports, so a controller can issue single steps one at a time. It can also hand the whole loop to the built-in sequencer, which runs one step per clock for the full operand width.

A setup command loads a double-width dividend into two registers. The upper half goes into the partial remainder and the lower half into a quotient shift register. The same command latches the divisor and prepares the status bits for an unsigned or a signed divide. In sequenced mode, each cycle rotates the quotient register left by one. Its top bit becomes the bit fed into the remainder, and the previous `t_bit` enters at the bottom. The step itself then runs.

After a sequenced unsigned run, one more left rotate of `t_bit` into the quotient register gives the quotient, and that rotate is left to the consumer. Remainder correction and divide-by-zero handling are left to the surrounding logic.

Top module: `dnr_divstep`

## Requirements
- R1: While reset is high and on the first cycle after it, remainder, quotient, q_bit, m_bit, t_bit, busy and done are all 0.
- R2: An unsigned setup (setup=1, setup_signed=0, unit idle) clears q_bit, m_bit and t_bit. It loads remainder with dividend bits [2W-1:W], loads quotient with dividend bits [W-1:0], and latches divisor. All of this is visible the next cycle.
- R3: A signed setup loads the same registers. It sets q_bit to dividend bit 2W-1 and m_bit to divisor bit W-1, and sets t_bit to q_bit XOR m_bit.
- R4: A step first shifts the remainder left by one, with the step's input bit entering bit 0. For a single step (step=1, idle) the input bit is the current t_bit. It then subtracts the latched divisor when the previous q_bit equals m_bit, and adds it otherwise, keeping W bits.
- R5: After a step, q_bit equals the XOR of three values: the remainder's bit W-1 before the shift, the carry (add) or borrow (subtract) of the W-bit operation, and m_bit.
- R6: After a step, t_bit is 1 exactly when q_bit equals m_bit, and m_bit is unchanged.
- R7: start=1 while idle raises busy on the next cycle. The unit then performs exactly W steps on W consecutive cycles. In each step the quotient register is rotated left: its old top bit becomes the step input bit and the old t_bit enters bit 0.
- R8: done is high for exactly one cycle, W cycles after the edge that accepted start, and busy falls at the same edge.
- R9: While busy, setup, step and start are ignored. While idle with no command, remainder, quotient and the status bits hold their values.
- R10: For an unsigned setup whose upper dividend half is below the divisor, after a sequenced run {quotient[W-2:0], t_bit} equals floor(dividend / divisor).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| setup | input | 1 | Load operands and initialise status bits |
| setup_signed | input | 1 | Selects signed (1) or unsigned (0) setup |
| step | input | 1 | Perform one division step |
| start | input | 1 | Launch a W-step sequenced run |
| divisor | input | W | Divisor, latched at setup |
| dividend | input | 2W | Double-width dividend, loaded at setup |
| remainder | output | W | Partial remainder |
| quotient | output | W | Quotient shift register |
| q_bit | output | 1 | Quotient/sign tracking status bit |
| m_bit | output | 1 | Divisor sign status bit |
| t_bit | output | 1 | Latest quotient bit |
| busy | output | 1 | Sequenced run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
The case that is hardest to reach from the ports is a step taken with q_bit and m_bit different, so that the divisor is added rather than subtracted, combined with a carry out of the top bit. An unsigned setup never produces it on the first step. The bench reaches it with signed setups that cover every pairing of dividend and divisor sign bits, followed by chains of single steps checked against an arithmetic model. Full sequenced runs carry the state through many add/subtract alternations, and in the middle of each run the bench injects setup and step requests that must leave the result untouched.

// File: rtl/dnr_pkg.sv
package dnr_pkg;

    // Decoded command accepted in a given cycle
    typedef enum logic [2:0] {
        CMD_NONE    = 3'd0,
        CMD_SETUP_U = 3'd1,
        CMD_SETUP_S = 3'd2,
        CMD_STEP    = 3'd3,
        CMD_RUN     = 3'd4
    } dnr_cmd_e;

    // Architecturally visible status bits
    typedef struct packed {
        logic q;
        logic m;
        logic t;
    } dnr_flags_t;

    // Operation chosen for one step
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } dnr_op_e;

    function automatic dnr_op_e pick_op(input dnr_flags_t f);
        return (f.q == f.m) ? OP_SUB : OP_ADD;
    endfunction

    function automatic dnr_flags_t signed_init(input logic dvd_msb, input logic dvs_msb);
        dnr_flags_t f;
        f.q = dvd_msb;
        f.m = dvs_msb;
        f.t = dvd_msb ^ dvs_msb;
        return f;
    endfunction

endpackage

// File: rtl/dnr_cmd_decode.sv
module dnr_cmd_decode
    import dnr_pkg::*;
(
    input  logic     setup,
    input  logic     setup_signed,
    input  logic     step,
    input  logic     start,
    input  logic     busy,
    output dnr_cmd_e cmd
);
    // Priority when idle: setup, then start, then single step.
    always_comb begin
        cmd = CMD_NONE;
        if (!busy) begin
            if (setup)
                cmd = setup_signed ? CMD_SETUP_S : CMD_SETUP_U;
            else if (start)
                cmd = CMD_RUN;
            else if (step)
                cmd = CMD_STEP;
        end
    end
endmodule

// File: rtl/dnr_step_core.sv
module dnr_step_core
    import dnr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] rem_in,
    input  dnr_flags_t   flags_in,
    input  logic         bit_in,
    input  logic [W-1:0] dvs,
    output logic [W-1:0] rem_out,
    output dnr_flags_t   flags_out
);
    logic [W-1:0] shifted;
    logic [W:0]   acc;
    logic         cy;
    logic         new_q;
    dnr_op_e      op;

    always_comb begin
        shifted = {rem_in[W-2:0], bit_in};
        op      = pick_op(flags_in);
        if (op == OP_SUB)
            acc = {1'b0, shifted} - {1'b0, dvs};
        else
            acc = {1'b0, shifted} + {1'b0, dvs};
        cy      = acc[W];
        new_q   = rem_in[W-1] ^ cy ^ flags_in.m;
        rem_out = acc[W-1:0];
        flags_out.q = new_q;
        flags_out.m = flags_in.m;
        flags_out.t = (new_q == flags_in.m);
    end
endmodule

// File: rtl/dnr_sequencer.sv
module dnr_sequencer #(
    parameter int W = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic launch,
    output logic running,
    output logic done
);
    localparam int CW = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            done    <= 1'b0;
            cnt     <= '0;
        end else begin
            done <= 1'b0;
            if (running) begin
                cnt <= cnt + CW'(1);
                if (cnt == LAST) begin
                    running <= 1'b0;
                    done    <= 1'b1;
                    cnt     <= '0;
                end
            end else if (launch) begin
                running <= 1'b1;
                cnt     <= '0;
            end
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8
    AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(running) && !running)); // R8
    AST_LAUNCH_STARTS: assert property (@(posedge clk) disable iff (rst)
        (launch && !running) |=> running); // R7
endmodule

// File: rtl/dnr_divstep.sv
module dnr_divstep
    import dnr_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               setup,
    input  logic               setup_signed,
    input  logic               step,
    input  logic               start,
    input  logic [WIDTH-1:0]   divisor,
    input  logic [2*WIDTH-1:0] dividend,
    output logic [WIDTH-1:0]   remainder,
    output logic [WIDTH-1:0]   quotient,
    output logic               q_bit,
    output logic               m_bit,
    output logic               t_bit,
    output logic               busy,
    output logic               done
);
    localparam int DW = 2 * WIDTH;

    dnr_cmd_e         cmd;
    dnr_flags_t       flags_r;
    dnr_flags_t       core_flags;
    logic [WIDTH-1:0] rem_r;
    logic [WIDTH-1:0] quo_r;
    logic [WIDTH-1:0] dvs_r;
    logic [WIDTH-1:0] core_rem;
    logic             run_active;
    logic             step_fire;
    logic             bit_in;

    dnr_cmd_decode u_dec (
        .setup        (setup),
        .setup_signed (setup_signed),
        .step         (step),
        .start        (start),
        .busy         (run_active),
        .cmd          (cmd)
    );

    dnr_sequencer #(.W(WIDTH)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .launch  (cmd == CMD_RUN),
        .running (run_active),
        .done    (done)
    );

    // Sequenced steps feed the quotient register's top bit; single steps feed T.
    assign step_fire = run_active || (cmd == CMD_STEP);
    assign bit_in    = run_active ? quo_r[WIDTH-1] : flags_r.t;

    dnr_step_core #(.W(WIDTH)) u_core (
        .rem_in    (rem_r),
        .flags_in  (flags_r),
        .bit_in    (bit_in),
        .dvs       (dvs_r),
        .rem_out   (core_rem),
        .flags_out (core_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_r   <= '0;
            quo_r   <= '0;
            dvs_r   <= '0;
            flags_r <= '0;
        end else begin
            unique case (cmd)
                CMD_SETUP_U, CMD_SETUP_S: begin
                    rem_r   <= dividend[DW-1:WIDTH];
                    quo_r   <= dividend[WIDTH-1:0];
                    dvs_r   <= divisor;
                    flags_r <= (cmd == CMD_SETUP_S)
                               ? signed_init(dividend[DW-1], divisor[WIDTH-1])
                               : '0;
                end
                default: begin
                    if (step_fire) begin
                        rem_r   <= core_rem;
                        flags_r <= core_flags;
                    end
                    if (run_active)
                        quo_r <= {quo_r[WIDTH-2:0], flags_r.t};
                end
            endcase
        end
    end

    assign remainder = rem_r;
    assign quotient  = quo_r;
    assign q_bit     = flags_r.q;
    assign m_bit     = flags_r.m;
    assign t_bit     = flags_r.t;
    assign busy      = run_active;

    AST_UNSIGNED_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (setup && !setup_signed && !busy) |=> (!q_bit && !m_bit && !t_bit)); // R2
    AST_SIGNED_T: assert property (@(posedge clk) disable iff (rst)
        (setup && setup_signed && !busy) |=> (t_bit == (q_bit ^ m_bit))); // R3
    AST_T_AFTER_STEP: assert property (@(posedge clk) disable iff (rst)
        step_fire |=> (t_bit == (q_bit == m_bit))); // R6
    AST_M_HELD: assert property (@(posedge clk) disable iff (rst)
        step_fire |=> $stable(m_bit)); // R6
    AST_BUSY_NO_SETUP: assert property (@(posedge clk) disable iff (rst)
        (busy && setup) |=> $stable(m_bit)); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !setup && !step && !start) |=>
            ($stable(remainder) && $stable(quotient) && $stable(t_bit))); // R9
endmodule

// File: tb/dnr_divstep_test.sv
`timescale 1ns/1ps
module dnr_divstep_test;
    localparam int W = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           setup = 1'b0;
    logic           setup_signed = 1'b0;
    logic           step = 1'b0;
    logic           start = 1'b0;
    logic [W-1:0]   divisor = '0;
    logic [2*W-1:0] dividend = '0;
    logic [W-1:0]   remainder;
    logic [W-1:0]   quotient;
    logic           q_bit, m_bit, t_bit, busy, done;

    always #2 clk = ~clk;

    dnr_divstep #(.WIDTH(W)) uut (
        .clk(clk), .rst(rst), .setup(setup), .setup_signed(setup_signed),
        .step(step), .start(start), .divisor(divisor), .dividend(dividend),
        .remainder(remainder), .quotient(quotient), .q_bit(q_bit),
        .m_bit(m_bit), .t_bit(t_bit), .busy(busy), .done(done)
    );

    int checks = 0;
    int errors = 0;

    // Bench model state
    logic [W-1:0] mrem, mquo, mdvs;
    logic         mq, mm, mt;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One step computed with integer arithmetic (R4, R5, R6)
    task automatic model_step(input logic bi);
        int  s, d, v;
        logic cy, nq;
        s = int'({mrem[W-2:0], bi});
        d = int'(mdvs);
        if (mq == mm) begin
            v  = s - d;
            cy = (v < 0);
        end else begin
            v  = s + d;
            cy = (v >= (1 << W));
        end
        nq   = mrem[W-1] ^ cy ^ mm;
        mrem = W'(v);
        mq   = nq;
        mt   = (nq == mm);
    endtask

    task automatic check_state(input string req);
        check({req, " rem"}, 32'(remainder), 32'(mrem));
        check({req, " quo"}, 32'(quotient), 32'(mquo));
        check({req, " q"},   32'(q_bit), 32'(mq));
        check({req, " m"},   32'(m_bit), 32'(mm));
        check({req, " t"},   32'(t_bit), 32'(mt));
    endtask

    task automatic do_setup(input logic sgn, input logic [2*W-1:0] dvd, input logic [W-1:0] dvs);
        @(negedge clk);
        setup = 1'b1; setup_signed = sgn; dividend = dvd; divisor = dvs;
        @(negedge clk);
        setup = 1'b0;
        mrem = dvd[2*W-1:W];
        mquo = dvd[W-1:0];
        mdvs = dvs;
        if (sgn) begin
            mq = dvd[2*W-1]; mm = dvs[W-1]; mt = mq ^ mm;   // R3
        end else begin
            mq = 1'b0; mm = 1'b0; mt = 1'b0;                // R2
        end
        check_state(sgn ? "R3" : "R2");
    endtask

    task automatic do_single_step();
        @(negedge clk);
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
        model_step(mt);
        check_state("R4/R5/R6 single");
    endtask

    task automatic do_run(input logic sgn, input logic [2*W-1:0] dvd);
        int n;
        logic [W-1:0] held;
        logic bi;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R7 busy after start", 32'(busy), 32'd1);
        n = 0;
        while (!done && n < W + 4) begin
            if (n == 2) begin
                // R9: requests while busy must be ignored
                step = 1'b1; setup = 1'b1; setup_signed = ~sgn;
                dividend = ~dvd; divisor = ~mdvs;
            end else begin
                step = 1'b0; setup = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        step = 1'b0; setup = 1'b0;
        check("R8 done latency", 32'(n), 32'(W));
        check("R7 busy dropped", 32'(busy), 32'd0);
        for (int k = 0; k < W; k++) begin
            bi   = mquo[W-1];
            mquo = {mquo[W-2:0], mt};
            model_step(bi);
        end
        check_state("R7/R9 run");
        if (!sgn && (dvd[2*W-1:W] < mdvs))
            check("R10 quotient", 32'({quotient[W-2:0], t_bit}),
                  32'(int'(dvd) / int'(mdvs)));
        held = remainder;
        @(negedge clk);
        check("R8 done one cycle", 32'(done), 32'd0);
        check("R9 hold after done", 32'(remainder), 32'(held));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [2*W-1:0] dvd;
        logic [W-1:0]   hi;
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 rem",  32'(remainder), 0);
        check("R1 quo",  32'(quotient), 0);
        check("R1 flags", 32'({q_bit, m_bit, t_bit}), 0);
        check("R1 busy/done", 32'({busy, done}), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", 32'({busy, done, q_bit, m_bit, t_bit}), 0);

        // R9: idle with no command holds state
        do_setup(1'b1, 16'hA5C3, 8'h37);
        repeat (3) @(negedge clk);
        check_state("R9 idle hold");

        // Signed setups over all sign pairings, followed by chains of single steps
        for (int a = 0; a < 64; a++) begin
            for (int b = 0; b < 8; b++) begin
                dvd = 16'((a * 1031 + 7) ^ (b << 13));
                do_setup(1'b1, dvd, 8'((b * 37 + a * 5 + 1) ^ ((b & 1) << 7)));
                for (int s = 0; s < 3; s++) do_single_step();
            end
        end

        // Unsigned sequenced divisions (R10)
        for (int d = 1; d < 256; d += 9) begin
            for (int h = 0; h < 4; h++) begin
                hi = W'((d - 1) * h / 3);
                for (int l = 0; l < 256; l += 43) begin
                    dvd = {hi, 8'(l)};
                    do_setup(1'b0, dvd, 8'(d));
                    do_run(1'b0, dvd);
                end
            end
        end

        // Signed sequenced runs through all sign pairings
        for (int a = 0; a < 40; a++) begin
            dvd = 16'(a * 1637 + 11);
            do_setup(1'b1, dvd, 8'(a * 29 + 3));
            do_run(1'b1, dvd);
        end

        // Chained: single step right after a run uses T as input bit (R4)
        do_setup(1'b0, 16'h1234, 8'h56);
        do_run(1'b0, 16'h1234);
        do_single_step();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule